// File: doc/BRIEF.md
# Banked Memory Address Translation Unit

This block sits beside the operand path of a 16-bit microcontroller core and turns each operand reference into a physical address. Two address spaces coexist. The low space, a 1024-location internal register file split into four banks, is reached either by an 8-bit register operand extended with a 2-bit register-bank select, or by any effective address below 0x400. Everything from 0x400 upward goes to the external bus. There the 16-bit effective address is extended with a 4-bit ROM bank number to give a 20-bit address.

Each access carries an addressing mode: direct, immediate, indirect, indexed or relative. Direct and immediate accesses name a register. Indirect, indexed and relative accesses form a 16-bit effective address from a register content or from the current code address, plus an optional offset. The routing decision follows from the result, so a linear walk steps from internal 0x3FF straight to external {bank,0x0400}. When the memory-expansion bit of the control register is clear, a fixed default ROM bank replaces the programmed one. Results leave the block one cycle after the request, with a valid strobe.

Top module: `addr_xlat_unit`

## Requirements
- R1: Mode code 0 (direct) gives an internal access at address {register-bank select, reg operand}. Codes 5 to 7 are treated as direct.
- R2: Mode code 1 (immediate) gives the same internal access for the destination register operand. The base and offset inputs have no effect on the result.
- R3: For modes 2 to 4, an effective address below 0x400 gives an internal access at the low 10 bits of that address, with no bank bits applied.
- R4: For modes 2 to 4, an effective address of 0x400 or more gives an external access at {effective ROM bank (4 bits), effective address (16 bits)}.
- R5: Mode code 2 (indirect) uses the base value as the effective address.
- R6: Mode code 3 (indexed) uses base plus offset, wrapped modulo 2^16 with no carry into the bank bits. The 0x400 test is applied to the wrapped sum.
- R7: Mode code 4 (relative) forms a jump or call target as the current address on the base input plus the offset, and routes it exactly like an indexed access.
- R8: Bit 4 of the control byte enables memory expansion. When it is set, the effective ROM bank is the programmed bank. When it is clear, the bank is DFLT_BANK (default 8), and the other control bits have no effect.
- R9: Bank and control writes are registered. A write takes effect on the access after the cycle of the write, not on an access in the same cycle.
- R10: The outputs are registered with a latency of one cycle, and out_valid follows acc_valid. On an internal result the external address is zero, and on an external result the internal address is zero. After reset, out_valid is low, both banks are 0 and expansion is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request strobe |
| acc_mode | input | 3 | Addressing mode code |
| acc_reg | input | 8 | Register operand (direct/immediate) |
| acc_base | input | 16 | Register content or current code address |
| acc_off | input | 16 | Index or jump offset |
| cfg_bank_we | input | 1 | Write strobe for both bank selects |
| cfg_rbank | input | 2 | New register-bank select |
| cfg_rombank | input | 4 | New ROM bank number |
| cfg_ctl_we | input | 1 | Write strobe for the control byte |
| cfg_ctl | input | 8 | New control byte, bit 4 = expansion enable |
| out_valid | output | 1 | Translated access valid |
| out_ext | output | 1 | 1 = external bus, 0 = internal register file |
| out_int_addr | output | 10 | Internal register-file address |
| out_ext_addr | output | 20 | External bus address |

## Verification
The assertions watch, on every cycle, the one-cycle valid latency and the mutual zeroing of the two address outputs. They also check that every external result lies at or above 0x400, that direct accesses land in the internal space on their register operand, and that indirect and indexed results carry the expected 16-bit effective address. Bank selection is left to the bench scenarios: the default bank when expansion is off, the write-versus-access ordering in one cycle, the boundary walk across 0x3FF/0x400 and the wrap of an indexed sum back into the internal space. These depend on the history of configuration writes.

// File: rtl/addr_xlat_pkg.sv
package addr_xlat_pkg;
  typedef enum logic [2:0] {
    MODE_DIRECT = 3'd0,
    MODE_IMM    = 3'd1,
    MODE_INDIR  = 3'd2,
    MODE_INDEX  = 3'd3,
    MODE_REL    = 3'd4
  } xlat_mode_e;
endpackage

// File: rtl/xlat_bank_regs.sv
module xlat_bank_regs #(
  parameter int RBANK_W   = 2,
  parameter int ROMBANK_W = 4,
  parameter int CTL_W     = 8,
  parameter int EXP_BIT   = 4,
  parameter logic [ROMBANK_W-1:0] DFLT_BANK = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bank_we,
  input  logic [RBANK_W-1:0]   rbank_in,
  input  logic [ROMBANK_W-1:0] rombank_in,
  input  logic                 ctl_we,
  input  logic [CTL_W-1:0]     ctl_in,
  output logic [RBANK_W-1:0]   rbank,
  output logic [ROMBANK_W-1:0] eff_bank
);
  logic [ROMBANK_W-1:0] rombank_q;
  logic                 expand_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbank     <= '0;
      rombank_q <= '0;
      expand_q  <= 1'b0;
    end else begin
      if (bank_we) begin
        rbank     <= rbank_in;
        rombank_q <= rombank_in;
      end
      if (ctl_we) expand_q <= ctl_in[EXP_BIT];
    end
  end

  assign eff_bank = expand_q ? rombank_q : DFLT_BANK;
endmodule

// File: rtl/xlat_ea_route.sv
module xlat_ea_route
  import addr_xlat_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int RBANK_W   = 2,
  parameter int ADDR_W    = 16,
  parameter int ROMBANK_W = 4
) (
  input  logic [2:0]                  mode,
  input  logic [REG_W-1:0]            reg_opnd,
  input  logic [ADDR_W-1:0]           base,
  input  logic [ADDR_W-1:0]           off,
  input  logic [RBANK_W-1:0]          rbank,
  input  logic [ROMBANK_W-1:0]        bank,
  output logic                        to_ext,
  output logic [REG_W+RBANK_W-1:0]    int_addr,
  output logic [ROMBANK_W+ADDR_W-1:0] ext_addr
);
  localparam int INT_W    = REG_W + RBANK_W;
  localparam int INT_SPAN = 1 << INT_W;

  xlat_mode_e  m;
  logic        use_ea;
  logic        add_off;
  logic [ADDR_W-1:0] ea;

  always_comb begin
    m = xlat_mode_e'(mode);
    use_ea  = (m == MODE_INDIR) || (m == MODE_INDEX) || (m == MODE_REL);
    add_off = (m == MODE_INDEX) || (m == MODE_REL);
    ea = base + (add_off ? off : '0);
    to_ext   = 1'b0;
    int_addr = '0;
    ext_addr = '0;
    if (!use_ea) begin
      int_addr = {rbank, reg_opnd};
    end else if (ea < ADDR_W'(INT_SPAN)) begin
      int_addr = ea[INT_W-1:0];
    end else begin
      to_ext   = 1'b1;
      ext_addr = {bank, ea};
    end
  end
endmodule

// File: rtl/addr_xlat_unit.sv
module addr_xlat_unit #(
  parameter int REG_W     = 8,
  parameter int RBANK_W   = 2,
  parameter int ADDR_W    = 16,
  parameter int ROMBANK_W = 4,
  parameter int CTL_W     = 8,
  parameter int EXP_BIT   = 4,
  parameter logic [ROMBANK_W-1:0] DFLT_BANK = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        acc_valid,
  input  logic [2:0]                  acc_mode,
  input  logic [REG_W-1:0]            acc_reg,
  input  logic [ADDR_W-1:0]           acc_base,
  input  logic [ADDR_W-1:0]           acc_off,
  input  logic                        cfg_bank_we,
  input  logic [RBANK_W-1:0]          cfg_rbank,
  input  logic [ROMBANK_W-1:0]        cfg_rombank,
  input  logic                        cfg_ctl_we,
  input  logic [CTL_W-1:0]            cfg_ctl,
  output logic                        out_valid,
  output logic                        out_ext,
  output logic [REG_W+RBANK_W-1:0]    out_int_addr,
  output logic [ROMBANK_W+ADDR_W-1:0] out_ext_addr
);
  localparam int INT_W = REG_W + RBANK_W;
  localparam int EXT_W = ROMBANK_W + ADDR_W;

  logic [RBANK_W-1:0]   rbank;
  logic [ROMBANK_W-1:0] eff_bank;
  logic                 nx_ext;
  logic [INT_W-1:0]     nx_int;
  logic [EXT_W-1:0]     nx_extaddr;

  xlat_bank_regs #(
    .RBANK_W(RBANK_W), .ROMBANK_W(ROMBANK_W), .CTL_W(CTL_W),
    .EXP_BIT(EXP_BIT), .DFLT_BANK(DFLT_BANK)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bank_we(cfg_bank_we), .rbank_in(cfg_rbank), .rombank_in(cfg_rombank),
    .ctl_we(cfg_ctl_we), .ctl_in(cfg_ctl),
    .rbank(rbank), .eff_bank(eff_bank)
  );

  xlat_ea_route #(
    .REG_W(REG_W), .RBANK_W(RBANK_W), .ADDR_W(ADDR_W), .ROMBANK_W(ROMBANK_W)
  ) u_route (
    .mode(acc_mode), .reg_opnd(acc_reg), .base(acc_base), .off(acc_off),
    .rbank(rbank), .bank(eff_bank),
    .to_ext(nx_ext), .int_addr(nx_int), .ext_addr(nx_extaddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_ext      <= 1'b0;
      out_int_addr <= '0;
      out_ext_addr <= '0;
    end else begin
      out_valid <= acc_valid;
      if (acc_valid) begin
        out_ext      <= nx_ext;
        out_int_addr <= nx_int;
        out_ext_addr <= nx_extaddr;
      end
    end
  end
endmodule

// File: rtl/addr_xlat_unit_chk.sv
module addr_xlat_unit_chk #(
  parameter int REG_W  = 8,
  parameter int RBANK_W = 2,
  parameter int ADDR_W = 16,
  parameter int ROMBANK_W = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        acc_valid,
  input logic [2:0]                  acc_mode,
  input logic [REG_W-1:0]            acc_reg,
  input logic [ADDR_W-1:0]           acc_base,
  input logic [ADDR_W-1:0]           acc_off,
  input logic                        out_valid,
  input logic                        out_ext,
  input logic [REG_W+RBANK_W-1:0]    out_int_addr,
  input logic [ROMBANK_W+ADDR_W-1:0] out_ext_addr
);
  localparam int INT_W = REG_W + RBANK_W;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(1 << INT_W);

  logic [ADDR_W-1:0] out_ea;
  assign out_ea = out_ext ? out_ext_addr[ADDR_W-1:0] : ADDR_W'(out_int_addr);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_valid);
  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !out_valid);
  // R10
  ext_zero_int_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ext) |-> (out_int_addr == '0));
  // R10
  int_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ext) |-> (out_ext_addr == '0));
  // R4
  ext_above_span_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ext) |-> (out_ext_addr[ADDR_W-1:0] >= SPAN));
  // R1
  direct_internal_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_mode == 3'd0) |=>
      (!out_ext && out_int_addr[REG_W-1:0] == $past(acc_reg)));
  // R5
  indirect_ea_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_mode == 3'd2) |=> (out_ea == $past(acc_base)));
  // R6
  indexed_ea_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_mode == 3'd3) |=>
      (out_ea == $past(acc_base + acc_off)));
endmodule

bind addr_xlat_unit addr_xlat_unit_chk #(
  .REG_W(REG_W), .RBANK_W(RBANK_W), .ADDR_W(ADDR_W), .ROMBANK_W(ROMBANK_W)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_mode(acc_mode),
  .acc_reg(acc_reg), .acc_base(acc_base), .acc_off(acc_off),
  .out_valid(out_valid), .out_ext(out_ext),
  .out_int_addr(out_int_addr), .out_ext_addr(out_ext_addr)
);

// File: tb/addr_xlat_unit_test.sv
`timescale 1ns/1ps
module addr_xlat_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_mode = '0;
  logic [7:0]  acc_reg = '0;
  logic [15:0] acc_base = '0, acc_off = '0;
  logic        cfg_bank_we = 1'b0, cfg_ctl_we = 1'b0;
  logic [1:0]  cfg_rbank = '0;
  logic [3:0]  cfg_rombank = '0;
  logic [7:0]  cfg_ctl = '0;
  logic        out_valid, out_ext;
  logic [9:0]  out_int_addr;
  logic [19:0] out_ext_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_xlat_unit uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_mode(acc_mode),
    .acc_reg(acc_reg), .acc_base(acc_base), .acc_off(acc_off),
    .cfg_bank_we(cfg_bank_we), .cfg_rbank(cfg_rbank), .cfg_rombank(cfg_rombank),
    .cfg_ctl_we(cfg_ctl_we), .cfg_ctl(cfg_ctl),
    .out_valid(out_valid), .out_ext(out_ext),
    .out_int_addr(out_int_addr), .out_ext_addr(out_ext_addr)
  );

  // {mode(4), reg(8), base(16), off(16), ext(4), int(12), extaddr(20)}
  // configuration during the table: rbank=2, rombank=3, expansion on
  localparam logic [79:0] VEC [12] = '{
    {4'd0, 8'h15, 16'h0000, 16'h0000, 4'd0, 12'h215, 20'h00000}, // R1
    {4'd1, 8'hA0, 16'hFFFF, 16'h1234, 4'd0, 12'h2A0, 20'h00000}, // R2
    {4'd2, 8'h00, 16'h03FE, 16'h0000, 4'd0, 12'h3FE, 20'h00000}, // R3
    {4'd2, 8'h00, 16'h03FF, 16'h7777, 4'd0, 12'h3FF, 20'h00000}, // R3
    {4'd2, 8'h00, 16'h0400, 16'h0000, 4'd1, 12'h000, 20'h30400}, // R4
    {4'd2, 8'h00, 16'h0401, 16'h0000, 4'd1, 12'h000, 20'h30401}, // R5
    {4'd3, 8'h00, 16'h1000, 16'h0234, 4'd1, 12'h000, 20'h31234}, // R6
    {4'd3, 8'h00, 16'hFFF0, 16'h0020, 4'd0, 12'h010, 20'h00000}, // R6 wrap
    {4'd3, 8'h00, 16'hFF00, 16'h0500, 4'd1, 12'h000, 20'h30400}, // R6 wrap
    {4'd4, 8'h00, 16'h2000, 16'h0010, 4'd1, 12'h000, 20'h32010}, // R7
    {4'd4, 8'h00, 16'h0100, 16'h0010, 4'd0, 12'h110, 20'h00000}, // R7
    {4'd2, 8'h00, 16'hFFFF, 16'h0000, 4'd1, 12'h000, 20'h3FFFF}  // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [2:0] m, input logic [7:0] r,
                        input logic [15:0] b, input logic [15:0] o);
    @(negedge clk);
    acc_valid = 1'b1; acc_mode = m; acc_reg = r; acc_base = b; acc_off = o;
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  task automatic write_banks(input logic [1:0] rb, input logic [3:0] romb);
    @(negedge clk);
    cfg_bank_we = 1'b1; cfg_rbank = rb; cfg_rombank = romb;
    @(negedge clk);
    cfg_bank_we = 1'b0;
  endtask

  task automatic write_ctl(input logic [7:0] c);
    @(negedge clk);
    cfg_ctl_we = 1'b1; cfg_ctl = c;
    @(negedge clk);
    cfg_ctl_we = 1'b0;
  endtask

  function automatic logic [31:0] packed_out();
    return {out_valid, out_ext, out_int_addr, out_ext_addr};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset valid", {31'd0, out_valid}, 32'd0);
    check("R10 reset addrs", {2'b0, out_int_addr, out_ext_addr}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // reset defaults: rbank 0, expansion off -> default bank 8
    access(3'd0, 8'h33, 16'h0, 16'h0);
    check("R10 reset rbank", packed_out(), {1'b1, 1'b0, 10'h033, 20'h0});
    access(3'd2, 8'h00, 16'h5000, 16'h0);
    check("R8 reset default bank", packed_out(), {1'b1, 1'b1, 10'h0, 20'h85000});

    write_banks(2'd2, 4'd3);
    write_ctl(8'h10);
    for (int i = 0; i < 12; i++) begin
      access(VEC[i][79:76], VEC[i][75:68], VEC[i][67:52], VEC[i][51:36]);
      check($sformatf("R1-table vector %0d", i), packed_out(),
            {1'b1, VEC[i][32], VEC[i][29:20], VEC[i][19:0]});
    end

    // codes 5..7 act as direct (R1)
    access(3'd6, 8'h7E, 16'h9000, 16'h0);
    check("R1 spare code", packed_out(), {1'b1, 1'b0, 10'h27E, 20'h0});

    // R10: idle cycle drops valid
    @(negedge clk); @(posedge clk); #1;
    check("R10 idle", {31'd0, out_valid}, 32'd0);

    // R8: expansion cleared with other control bits set
    write_ctl(8'hEF);
    access(3'd2, 8'h00, 16'h1234, 16'h0);
    check("R8 expansion off", packed_out(), {1'b1, 1'b1, 10'h0, 20'h81234});
    write_ctl(8'h10);
    access(3'd2, 8'h00, 16'h1234, 16'h0);
    check("R8 expansion on", packed_out(), {1'b1, 1'b1, 10'h0, 20'h31234});

    // R9: write and access in the same cycle use the old banks
    @(negedge clk);
    cfg_bank_we = 1'b1; cfg_rbank = 2'd1; cfg_rombank = 4'd5;
    acc_valid = 1'b1; acc_mode = 3'd0; acc_reg = 8'h05;
    @(posedge clk); #1;
    check("R9 same cycle", packed_out(), {1'b1, 1'b0, 10'h205, 20'h0});
    @(negedge clk);
    cfg_bank_we = 1'b0;
    @(posedge clk); #1;
    acc_valid = 1'b0;
    check("R9 next access", packed_out(), {1'b1, 1'b0, 10'h105, 20'h0});
    access(3'd4, 8'h00, 16'hA000, 16'h0F00);
    check("R9 new rom bank", packed_out(), {1'b1, 1'b1, 10'h0, 20'h5AF00});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule